// File: doc/BRIEF.md
# Routed Interrupt Controller with Software-Raised Sources

This block gathers 32 interrupt sources into one pending vector and steers each pending, enabled source onto one of five interrupt lines toward a processor. Every source owns a configuration word on a small register bus with 64-bit data. The word holds an enable flag, a 4-bit line-select field and a 23-bit target-thread tag. The tag is only stored and returned on reads.

The lower sixteen sources are hardware sources. Each one catches a rising edge on its input pin and holds it as a pending bit until software clears it. The upper sixteen sources have no hardware path. Software raises them through a write-one-to-set register, which makes them usable as inter-processor interrupts. A write-one-to-clear register acknowledges any source. Bus reads are registered, so read data appears in the cycle after the read strobe.

Top module: `irq_router`

## Requirements
- R1: After reset every configuration word, every pending bit, the read data and all five lines are zero.
- R2: The configuration word of source n sits at byte address n*8 (n = 0..31). Its bits [3:0] (line select), [30:8] (thread tag) and [31] (enable) are stored and read back. All other bits read as zero.
- R3: A read of byte address 0x100 returns the pending vector in bits [31:0], with zero above it. Read data is valid in the cycle after the read strobe and reflects the state before that clock edge.
- R4: A write to byte address 0x108 sets each pending bit whose data bit is 1 and leaves the others unchanged. This holds for all 32 sources.
- R5: A write to byte address 0x110 clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R6: A hardware source (0..15) becomes pending on a low-to-high change of its input. It stays pending until it is cleared. An input that is held high does not set the bit again after a clear.
- R7: If a hardware edge arrives in the same cycle as a clear of that bit, the bit ends up set.
- R8: Inputs 16..31 have no effect. Those pending bits change only through the set and clear registers.
- R9: Line j (0..4) is high exactly when at least one source is pending, enabled and has a select equal to j. Select values 5..15 drive no line.
- R10: A disabled source drives no line, but its pending bit still reads back.
- R11: Writes to the pending address (0x100) and to unmapped addresses change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| irq_in | input | 32 | Source inputs (only 0..15 are used) |
| irq_out | output | 5 | Routed interrupt lines |

## Verification
A corrupted pending bit or configuration field shows up on the interrupt lines in the cycle right after the faulty update, because the lines are a direct function of stored state. A pending read exposes the same fault one cycle after the read strobe. The bench therefore compares all five lines after every single cycle against an independent model, and reads the pending and configuration words often. A lost edge, a wrong clear priority or a mis-decoded select field is caught at its first visible consequence, not at the end of a sequence.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Configuration word layout (field positions are part of the contract)
  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 4;
  localparam int TAG_LSB = 8;
  localparam int TAG_W   = 23;
  localparam int EN_BIT  = 31;

  // Word index of control registers inside the upper address half
  localparam int CTRL_PEND = 0;
  localparam int CTRL_SET  = 1;
  localparam int CTRL_CLR  = 2;

  typedef struct packed {
    logic             en;
    logic [TAG_W-1:0] tag;
    logic [SEL_W-1:0] sel;
  } src_cfg_t;

  function automatic logic [63:0] cfg_to_word(src_cfg_t c);
    logic [63:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[TAG_LSB +: TAG_W] = c.tag;
    w[EN_BIT]           = c.en;
    return w;
  endfunction

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_word,
  output src_cfg_t [NUM_SRC-1:0]      cfg_q
);

  src_cfg_t decoded;

  always_comb begin
    decoded.sel = wr_word[SEL_LSB +: SEL_W];
    decoded.tag = wr_word[TAG_LSB +: TAG_W];
    decoded.en  = wr_word[EN_BIT];
  end

  logic unused_word_bits;
  assign unused_word_bits = ^{wr_word[DATA_W-1:EN_BIT+1], wr_word[TAG_LSB-1:SEL_W]};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_word
    logic     load;
    src_cfg_t nxt;

    always_comb begin
      load = wr_en && (wr_idx == IDX_W'(s));
      nxt  = load ? decoded : cfg_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[s] <= '0;
      else if (load) cfg_q[s] <= nxt;
    end
  end

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
  parameter int NUM_SRC = 32,
  parameter int NUM_HW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pend_q
);

  logic [NUM_HW-1:0]  prev_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] clr_v;

  always_comb begin
    set_v = set_stb ? mask : '0;
    clr_v = clr_stb ? mask : '0;
  end

  // Previous input level of hardware sources for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_in[NUM_HW-1:0];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_HW) begin : g_hw
      logic rise;
      always_comb begin
        rise      = src_in[s] && !prev_q[s];
        // A fresh edge outranks a simultaneous clear
        pend_d[s] = (pend_q[s] && !clr_v[s]) || set_v[s] || rise;
      end
    end else begin : g_soft
      always_comb pend_d[s] = (pend_q[s] && !clr_v[s]) || set_v[s];
    end
  end

  logic unused_soft_in;
  assign unused_soft_in = ^src_in[NUM_SRC-1:NUM_HW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/irq_out_router.sv
module irq_out_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 5
) (
  input  logic [NUM_SRC-1:0]     pend,
  input  src_cfg_t [NUM_SRC-1:0] cfg,
  output logic [NUM_OUT-1:0]     lines
);

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_line
    logic [NUM_SRC-1:0] hit;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
        hit[s] = pend[s] && cfg[s].en && (cfg[s].sel == SEL_W'(j));
      end
      lines[j] = |hit;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_HW  = 16,
  parameter int NUM_OUT = 5,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_OUT-1:0] irq_out
);

  src_cfg_t [NUM_SRC-1:0] cfg_q;
  logic [NUM_SRC-1:0]     pend_q;
  logic                   ctrl_region;
  logic [IDX_W-1:0]       word_idx;
  logic                   cfg_wr, set_wr, clr_wr;
  logic [DATA_W-1:0]      rd_next;
  logic [DATA_W-1:0]      rdata_q;

  // Address decode: lower half holds per-source words, upper half control
  always_comb begin
    ctrl_region = bus_addr[ADDR_W-1];
    word_idx    = bus_addr[3 +: IDX_W];
    cfg_wr      = bus_wr && !ctrl_region;
    set_wr      = bus_wr && ctrl_region && (word_idx == IDX_W'(CTRL_SET));
    clr_wr      = bus_wr && ctrl_region && (word_idx == IDX_W'(CTRL_CLR));
  end

  logic unused_addr_low;
  assign unused_addr_low = ^{bus_addr[2:0], bus_wdata[DATA_W-1:NUM_SRC]};

  irq_cfg_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_idx  (word_idx),
    .wr_word (bus_wdata),
    .cfg_q   (cfg_q)
  );

  irq_pend_tracker #(.NUM_SRC(NUM_SRC), .NUM_HW(NUM_HW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (irq_in),
    .set_stb (set_wr),
    .clr_stb (clr_wr),
    .mask    (bus_wdata[NUM_SRC-1:0]),
    .pend_q  (pend_q)
  );

  irq_out_router #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .pend  (pend_q),
    .cfg   (cfg_q),
    .lines (irq_out)
  );

  // Read path
  always_comb begin
    rd_next = '0;
    if (!ctrl_region) begin
      rd_next = cfg_to_word(cfg_q[word_idx]);
    end else if (word_idx == IDX_W'(CTRL_PEND)) begin
      rd_next[NUM_SRC-1:0] = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_HW  = 16,
  parameter int NUM_OUT = 5,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_OUT-1:0] irq_out,
  input logic [NUM_SRC-1:0] pend
);

  localparam logic [NUM_SRC-1:0] SOFT_MASK = {NUM_SRC{1'b1}} << NUM_HW;

  logic set_wr, clr_wr;
  logic [NUM_SRC-1:0] wmask;
  assign set_wr = bus_wr && bus_addr[ADDR_W-1] && (bus_addr[3 +: IDX_W] == IDX_W'(CTRL_SET));
  assign clr_wr = bus_wr && bus_addr[ADDR_W-1] && (bus_addr[3 +: IDX_W] == IDX_W'(CTRL_CLR));
  assign wmask  = bus_wdata[NUM_SRC-1:0];

  // R1: held in reset, nothing is pending and no line is raised
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (pend == '0 && irq_out == '0);
    end
  end

  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pend & $past(wmask)) == $past(wmask)));

  a_r5_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend & $past(wmask) & SOFT_MASK) == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(pend) & ~pend) == '0));

  a_r8_soft_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set_wr |=> ((pend & ~$past(pend) & SOFT_MASK) == '0));

  a_r10_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> (pend != '0));

endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_HW(NUM_HW), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .pend      (pend_q)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam logic [8:0]  A_PEND = 9'h100;
  localparam logic [8:0]  A_SET  = 9'h108;
  localparam logic [8:0]  A_CLR  = 9'h110;
  localparam logic [63:0] CFG_MASK = 64'h0000_0000_FFFF_FF0F;
  localparam logic [31:0] HW_MASK  = 32'h0000_FFFF;

  logic        clk, rst_n, bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [63:0] bus_wdata, bus_rdata;
  logic [31:0] irq_in;
  logic [4:0]  irq_out;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp, n_bad;
  bit done;

  logic [63:0] cfg_m [32];
  logic [31:0] pend_m, prev_m;

  function automatic logic [63:0] mdl_read(logic [8:0] a);
    if (!a[8]) return cfg_m[a[7:3]];
    if (a[7:3] == 5'd0) return {32'b0, pend_m};
    return 64'b0;
  endfunction

  function automatic logic [4:0] mdl_lines();
    logic [4:0] l;
    l = '0;
    for (int s = 0; s < 32; s++)
      if (pend_m[s] && cfg_m[s][31] && cfg_m[s][3:0] < 4'd5)
        l[cfg_m[s][2:0]] = 1'b1;
    return l;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle; called at a falling edge, returns at the next falling edge
  task automatic step(int op, logic [8:0] a, logic [63:0] d, logic [31:0] in, string tag);
    logic [63:0] exp_rd;
    logic [31:0] setv, clrv, edges;
    bus_wr = (op == 1); bus_rd = (op == 2);
    bus_addr = a; bus_wdata = d; irq_in = in;
    exp_rd = mdl_read(a);
    @(posedge clk);
    setv  = (op == 1 && a == A_SET) ? d[31:0] : 32'b0;
    clrv  = (op == 1 && a == A_CLR) ? d[31:0] : 32'b0;
    edges = in & ~prev_m & HW_MASK;
    pend_m = (pend_m & ~clrv) | setv | edges;
    prev_m = in;
    if (op == 1 && !a[8]) cfg_m[a[7:3]] = d & CFG_MASK;
    @(negedge clk);
    check({tag, " lines"}, {59'b0, irq_out}, {59'b0, mdl_lines()});
    if (op == 2) check({tag, " read"}, bus_rdata, exp_rd);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] cfgw(bit en, logic [3:0] sel, logic [22:0] tag);
    return {32'b0, en, tag, 4'b0, sel};
  endfunction

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] in;
    void'($urandom(32'd4242));
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
    for (int s = 0; s < 32; s++) cfg_m[s] = '0;
    pend_m = '0; prev_m = '0; in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 lines", {59'b0, irq_out}, 64'b0);
    check("R1 rdata", bus_rdata, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(2, A_PEND, 0, in, "R1 pend");
    step(2, 9'h038, 0, in, "R1 cfg");

    // R2: field storage and masking
    step(1, 9'h038, 64'hFFFF_FFFF_FFFF_FFFF, in, "R2");
    step(2, 9'h038, 0, in, "R2");
    step(1, 9'h0F8, 64'hA5A5_0000_1234_56F3, in, "R2");
    step(2, 9'h0F8, 0, in, "R2");

    // R4, R9: software source routed to line 3
    step(1, 9'h0B0, cfgw(1, 4'd3, 23'h11), in, "R9");
    step(1, A_SET, 64'h0040_0000, in, "R4");
    step(2, A_PEND, 0, in, "R4 R3");
    // R9: select beyond the last line drives nothing
    step(1, 9'h0A0, cfgw(1, 4'd7, 23'h0), in, "R9");
    step(1, A_SET, 64'hFFFF_FFFF_0010_0000, in, "R9");
    // R10: disabled source pending but silent
    step(1, 9'h090, cfgw(0, 4'd0, 23'h5), in, "R10");
    step(1, A_SET, 64'h0004_0000, in, "R10");
    step(2, A_PEND, 0, in, "R10");
    // R5: clear
    step(1, A_CLR, 64'h0044_0000, in, "R5");
    step(2, A_PEND, 0, in, "R5");

    // R6: edge on source 2 routed to line 0, clear while high
    step(1, 9'h010, cfgw(1, 4'd0, 23'h0), in, "R6");
    in[2] = 1'b1;
    step(0, 0, 0, in, "R6");
    step(1, A_CLR, 64'h4, in, "R6");
    step(2, A_PEND, 0, in, "R6 held high");
    // R7: edge together with clear
    in[2] = 1'b0;
    step(1, A_SET, 64'h4, in, "R7");
    in[2] = 1'b1;
    step(1, A_CLR, 64'h4, in, "R7");
    step(2, A_PEND, 0, in, "R7");
    // R8: upper inputs ignored
    in[31:16] = 16'hFFFF;
    step(0, 0, 0, in, "R8");
    step(2, A_PEND, 0, in, "R8");
    in = '0;
    // R11: pending address write and unmapped addresses
    step(1, A_PEND, 64'hFFFF_FFFF_FFFF_FFFF, in, "R11");
    step(1, 9'h1F8, 64'hFFFF_FFFF_FFFF_FFFF, in, "R11");
    step(2, A_PEND, 0, in, "R11");
    step(2, 9'h118, 0, in, "R11");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [8:0]  a;
      logic [63:0] d;
      r = $urandom % 10;
      if ($urandom % 6 == 0) in = in ^ (32'd1 << ($urandom % 32));
      if (r < 3) begin
        a = {1'b0, 5'($urandom % 32), 3'b0};
        d = {$urandom, $urandom};
        d[3:0] = 4'($urandom % 8);
        step(1, a, d, in, "R2 R9");
      end else if (r < 5) begin
        d = {32'b0, $urandom & $urandom};
        step(1, A_SET, d, in, "R4 R9");
      end else if (r < 7) begin
        d = {32'b0, $urandom | $urandom};
        step(1, A_CLR, d, in, "R5 R9");
      end else if (r < 9) begin
        step(2, A_PEND, 0, in, "R3 R6 R7 R8");
      end else begin
        a = {1'b0, 5'($urandom % 32), 3'b0};
        step(2, a, 0, in, "R2");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule